// File: doc/BRIEF.md
# Latency-Hiding Warp Scheduler

This block is a single issue scheduler for a pool of resident warps. Every cycle it looks at which warps are ready, grants one of them in rotating order, and raises a strobe saying that warp's next instruction goes out this cycle. Moving from one warp to another costs nothing: each warp's state stays in place, so consecutive cycles may issue from different warps.

When the instruction issued in a cycle is flagged as a memory load, the issuing warp is put to sleep for a programmable number of cycles. A per-warp down-counter holds the remaining wait. While other warps are awake, the pipe keeps issuing and the wait is hidden. When every resident warp is asleep, the cycle is a bubble. Two counters record issue cycles and bubble cycles, and their ratio gives the utilization of the issue slot.

A configuration input sets how many warps are resident. The valid range is 1 to the pool size. Only warps with an index below that number take part in selection.

Top module: `warp_sched`

## Requirements
- R1: In any cycle, at most one warp is granted. `issue_vld` high means `sel_warp` is a resident warp whose stall counter is zero.
- R2: `bubble` is high exactly in the cycles where no resident warp is ready. In those cycles `issue_vld` is low.
- R3: If a warp issues with `issue_is_load` high and `cfg_mem_lat` = L > 0, that warp is not granted in the L cycles that follow the issue cycle. It is ready again in the cycle after those L cycles.
- R4: If a load issues with `cfg_mem_lat` = 0, the warp does not stall. A lone resident warp then issues on every cycle.
- R5: The search for a grant starts at the warp after the last one granted and wraps from the highest resident index back to warp 0. After reset, the first grant goes to warp 0.
- R6: A warp whose index is equal to or above `cfg_warps` is never granted, whatever its state.
- R7: `issued_cnt` rises by one in the cycle after each cycle with `issue_vld` high.
- R8: `idle_cnt` rises by one in the cycle after each cycle with `bubble` high.
- R9: Reset (`rst_n` low) sets both counters to zero and clears every stall counter. Every resident warp is ready on the first cycle after reset, even when the reset interrupts a pending stall.

Ports of the top module, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_warps | input | $clog2(NUM_WARPS)+1 | Number of resident warps (1..NUM_WARPS) |
| cfg_mem_lat | input | LAT_W | Stall length in cycles applied when a load issues |
| issue_is_load | input | 1 | The instruction issued this cycle is a memory load |
| sel_warp | output | $clog2(NUM_WARPS) | Index of the granted warp |
| issue_vld | output | 1 | An instruction issues this cycle |
| bubble | output | 1 | No resident warp is ready this cycle |
| issued_cnt | output | CNT_W | Number of cycles with an issue |
| idle_cnt | output | CNT_W | Number of bubble cycles |

## Verification
The main pattern is two resident warps where every issue is a load with a latency of three. This run must produce a fixed issue, issue, bubble, bubble rhythm. That rhythm separates a correct stall length from one that is off by one, and separates a correct bubble count from a wrong one. A second pattern uses four warps with no loads while warp 0 is still asleep. It shows that rotation skips a stalled warp and wraps at the resident limit rather than at the pool size. A full-pool sweep checks wrap-around at the top index. A single warp with latency zero tells "no stall" apart from "one-cycle stall". Finally, a long stall is cut short by reset, which checks that reset clears the pending wait and the counters.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

  // Advance a warp index by a step, wrapping at the pool size.
  function automatic int unsigned wrap_add(input int unsigned base,
                                           input int unsigned step,
                                           input int unsigned pool);
    int unsigned s;
    s = base + step;
    if (s >= pool) s = s - pool;
    return s;
  endfunction

endpackage

// File: rtl/warp_stall_ctr.sv
module warp_stall_ctr #(
  parameter int LAT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [LAT_W-1:0] load_val,
  output logic             busy
);

  logic [LAT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_en)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/ws_rr_pick.sv
module ws_rr_pick
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 16,
  parameter int IDX_W     = $clog2(NUM_WARPS)
) (
  input  logic [NUM_WARPS-1:0] req,
  input  logic [IDX_W-1:0]     last,
  output logic [IDX_W-1:0]     gnt_idx,
  output logic                 gnt_vld
);

  // Scan from farthest to nearest so the nearest requester after 'last' wins.
  always_comb begin
    gnt_idx = '0;
    gnt_vld = 1'b0;
    for (int k = NUM_WARPS; k >= 1; k--) begin
      int unsigned p;
      p = wrap_add(int'(last), k, NUM_WARPS);
      if (req[p]) begin
        gnt_idx = IDX_W'(p);
        gnt_vld = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ws_perf.sv
module ws_perf #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_issue,
  input  logic             inc_idle,
  output logic [CNT_W-1:0] issued_cnt,
  output logic [CNT_W-1:0] idle_cnt
);

  logic [CNT_W-1:0] iss_q, iss_d, idl_q, idl_d;

  always_comb begin
    iss_d = iss_q;
    idl_d = idl_q;
    if (inc_issue) iss_d = iss_q + 1'b1;
    if (inc_idle)  idl_d = idl_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_q <= '0;
      idl_q <= '0;
    end else begin
      iss_q <= iss_d;
      idl_q <= idl_d;
    end
  end

  assign issued_cnt = iss_q;
  assign idle_cnt   = idl_q;

endmodule

// File: rtl/warp_sched.sv
module warp_sched #(
  parameter int NUM_WARPS = 16,
  parameter int LAT_W     = 10,
  parameter int CNT_W     = 32,
  localparam int IDX_W    = $clog2(NUM_WARPS),
  localparam int CFG_W    = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_warps,
  input  logic [LAT_W-1:0] cfg_mem_lat,
  input  logic             issue_is_load,
  output logic [IDX_W-1:0] sel_warp,
  output logic             issue_vld,
  output logic             bubble,
  output logic [CNT_W-1:0] issued_cnt,
  output logic [CNT_W-1:0] idle_cnt
);

  logic [NUM_WARPS-1:0] stall_busy;
  logic [NUM_WARPS-1:0] resident;
  logic [NUM_WARPS-1:0] ready;
  logic [IDX_W-1:0]     last_q, last_d;
  logic [IDX_W-1:0]     gnt_idx;
  logic                 gnt_vld;

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
    logic ld_here;
    assign resident[g] = (CFG_W'(g) < cfg_warps);
    assign ready[g]    = resident[g] & ~stall_busy[g];
    assign ld_here     = gnt_vld & issue_is_load & (gnt_idx == IDX_W'(g));

    warp_stall_ctr #(.LAT_W(LAT_W)) u_stall (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (ld_here),
      .load_val (cfg_mem_lat),
      .busy     (stall_busy[g])
    );
  end

  ws_rr_pick #(.NUM_WARPS(NUM_WARPS), .IDX_W(IDX_W)) u_pick (
    .req     (ready),
    .last    (last_q),
    .gnt_idx (gnt_idx),
    .gnt_vld (gnt_vld)
  );

  always_comb begin
    last_d = last_q;
    if (gnt_vld) last_d = gnt_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IDX_W'(NUM_WARPS - 1);
    else        last_q <= last_d;
  end

  ws_perf #(.CNT_W(CNT_W)) u_perf (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_issue  (gnt_vld),
    .inc_idle   (~gnt_vld),
    .issued_cnt (issued_cnt),
    .idle_cnt   (idle_cnt)
  );

  assign sel_warp  = gnt_idx;
  assign issue_vld = gnt_vld;
  assign bubble    = ~gnt_vld;

endmodule

// File: rtl/warp_sched_chk.sv
module warp_sched_chk #(
  parameter int NUM_WARPS = 16,
  parameter int LAT_W     = 10,
  parameter int CNT_W     = 32,
  localparam int IDX_W    = $clog2(NUM_WARPS),
  localparam int CFG_W    = IDX_W + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CFG_W-1:0]     cfg_warps,
  input logic [LAT_W-1:0]     cfg_mem_lat,
  input logic                 issue_is_load,
  input logic [IDX_W-1:0]     sel_warp,
  input logic                 issue_vld,
  input logic                 bubble,
  input logic [CNT_W-1:0]     issued_cnt,
  input logic [CNT_W-1:0]     idle_cnt,
  input logic [NUM_WARPS-1:0] stall_busy
);

  logic [NUM_WARPS-1:0] awake_in_range;
  always_comb begin
    for (int i = 0; i < NUM_WARPS; i++)
      awake_in_range[i] = (i < int'(cfg_warps)) && !stall_busy[i];
  end

  // R1
  sel_resident_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> ({1'b0, sel_warp} < cfg_warps));

  // R1
  sel_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> !stall_busy[sel_warp]);

  // R2
  bubble_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |-> (awake_in_range == '0 && !issue_vld));

  // R3
  load_sleeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && issue_is_load && cfg_mem_lat != '0) |=> stall_busy[$past(sel_warp)]);

  // R7
  issue_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |=> (issued_cnt == $past(issued_cnt) + 1'b1));

  // R8
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> (idle_cnt == $past(idle_cnt) + 1'b1));

endmodule

bind warp_sched warp_sched_chk #(
  .NUM_WARPS (NUM_WARPS),
  .LAT_W     (LAT_W),
  .CNT_W     (CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_warps     (cfg_warps),
  .cfg_mem_lat   (cfg_mem_lat),
  .issue_is_load (issue_is_load),
  .sel_warp      (sel_warp),
  .issue_vld     (issue_vld),
  .bubble        (bubble),
  .issued_cnt    (issued_cnt),
  .idle_cnt      (idle_cnt),
  .stall_busy    (stall_busy)
);

// File: tb/warp_sched_tb.sv
module warp_sched_tb;

  localparam int NW    = 16;
  localparam int LAT_W = 10;
  localparam int CNT_W = 32;
  localparam int NV    = 22;

  logic             clk;
  logic             rst_n;
  logic [4:0]       cfg_warps;
  logic [LAT_W-1:0] cfg_mem_lat;
  logic             issue_is_load;
  logic [3:0]       sel_warp;
  logic             issue_vld;
  logic             bubble;
  logic [CNT_W-1:0] issued_cnt;
  logic [CNT_W-1:0] idle_cnt;

  int checks = 0;
  int errors = 0;

  warp_sched #(.NUM_WARPS(NW), .LAT_W(LAT_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_warps(cfg_warps), .cfg_mem_lat(cfg_mem_lat),
    .issue_is_load(issue_is_load), .sel_warp(sel_warp), .issue_vld(issue_vld),
    .bubble(bubble), .issued_cnt(issued_cnt), .idle_cnt(idle_cnt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Row: {cfg_warps[4:0], lat[3:0], load, exp_vld, exp_sel[3:0]}
  localparam logic [14:0] VEC [NV] = '{
    {5'd2, 4'd3, 1'b1, 1'b1, 4'd0},   // two warps, latency 3
    {5'd2, 4'd3, 1'b1, 1'b1, 4'd1},
    {5'd2, 4'd3, 1'b1, 1'b0, 4'd0},
    {5'd2, 4'd3, 1'b1, 1'b0, 4'd0},
    {5'd2, 4'd3, 1'b1, 1'b1, 4'd0},
    {5'd2, 4'd3, 1'b1, 1'b1, 4'd1},
    {5'd2, 4'd3, 1'b1, 1'b0, 4'd0},
    {5'd2, 4'd3, 1'b1, 1'b0, 4'd0},
    {5'd2, 4'd3, 1'b1, 1'b1, 4'd0},
    {5'd4, 4'd0, 1'b0, 1'b1, 4'd1},   // four warps, warp 0 still asleep
    {5'd4, 4'd0, 1'b0, 1'b1, 4'd2},
    {5'd4, 4'd0, 1'b0, 1'b1, 4'd3},
    {5'd4, 4'd0, 1'b0, 1'b1, 4'd0},
    {5'd4, 4'd0, 1'b0, 1'b1, 4'd1},
    {5'd16, 4'd0, 1'b1, 1'b1, 4'd2},  // full pool, zero-latency loads
    {5'd16, 4'd0, 1'b1, 1'b1, 4'd3},
    {5'd16, 4'd0, 1'b1, 1'b1, 4'd4},
    {5'd1, 4'd2, 1'b1, 1'b1, 4'd0},   // single warp, latency 2
    {5'd1, 4'd2, 1'b1, 1'b0, 4'd0},
    {5'd1, 4'd2, 1'b1, 1'b0, 4'd0},
    {5'd1, 4'd0, 1'b0, 1'b1, 4'd0},
    {5'd1, 4'd0, 1'b0, 1'b1, 4'd0}
  };

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    rst_n = 1'b0;
    cfg_warps = 5'd2;
    cfg_mem_lat = '0;
    issue_is_load = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R9: counters clear while reset is held
    chk(issued_cnt == 0, "R9 issued_cnt in reset", int'(issued_cnt), 0);
    chk(idle_cnt == 0, "R9 idle_cnt in reset", int'(idle_cnt), 0);

    // Table walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i == 0) rst_n = 1'b1;
      cfg_warps     = VEC[i][14:10];
      cfg_mem_lat   = LAT_W'(VEC[i][9:6]);
      issue_is_load = VEC[i][5];
      #1;
      chk(issue_vld == VEC[i][4], $sformatf("R1/R3 row %0d issue_vld", i),
          int'(issue_vld), int'(VEC[i][4]));
      chk(bubble == !VEC[i][4], $sformatf("R2 row %0d bubble", i),
          int'(bubble), int'(!VEC[i][4]));
      if (VEC[i][4])
        chk(sel_warp == VEC[i][3:0], $sformatf("R5/R6 row %0d sel_warp", i),
            int'(sel_warp), int'(VEC[i][3:0]));
    end

    // R7, R8: 16 issue cycles and 6 bubble cycles in the table
    @(negedge clk); #1;
    chk(issued_cnt == 16, "R7 issued_cnt after table", int'(issued_cnt), 16);
    chk(idle_cnt == 6, "R8 idle_cnt after table", int'(idle_cnt), 6);

    // R9: reset in the middle of a long stall
    @(negedge clk);
    cfg_warps = 5'd1; cfg_mem_lat = LAT_W'(20); issue_is_load = 1'b1;
    #1;
    chk(issue_vld == 1'b1, "R9 pre-reset load issues", int'(issue_vld), 1);
    @(negedge clk); #1;
    chk(bubble == 1'b1, "R3 warp asleep before reset", int'(bubble), 1);
    rst_n = 1'b0;
    #1;
    chk(issued_cnt == 0, "R9 issued_cnt cleared", int'(issued_cnt), 0);
    chk(idle_cnt == 0, "R9 idle_cnt cleared", int'(idle_cnt), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(issue_vld == 1'b1, "R9 stall cleared by reset", int'(issue_vld), 1);
    chk(sel_warp == 4'd0, "R9 first grant warp 0", int'(sel_warp), 0);

    // R3: exact stall length of 20 cycles
    @(negedge clk);
    issue_is_load = 1'b0;
    for (int c = 0; c < 20; c++) begin
      #1;
      chk(bubble == 1'b1, $sformatf("R3 stall cycle %0d", c), int'(bubble), 1);
      @(negedge clk);
    end
    #1;
    chk(issue_vld == 1'b1, "R3 warp ready after latency", int'(issue_vld), 1);

    // R5, R6: full-pool sweep, last grant was warp 0
    for (int c = 1; c <= NW; c++) begin
      @(negedge clk);
      cfg_warps = 5'd16; cfg_mem_lat = '0; issue_is_load = 1'b0;
      #1;
      chk(sel_warp == 4'(c % NW) && issue_vld, $sformatf("R5 sweep step %0d", c),
          int'(sel_warp), c % NW);
    end

    // R4: zero latency load on a lone warp never stalls
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      cfg_warps = 5'd1; cfg_mem_lat = '0; issue_is_load = 1'b1;
      #1;
      chk(issue_vld == 1'b1 && sel_warp == 4'd0, $sformatf("R4 back-to-back %0d", c),
          int'(issue_vld), 1);
    end

    summary();
  end

endmodule